// File: doc/BRIEF.md
# Streaming Record Cross-Correlator

The block takes records of signed samples from a streaming input and correlates each one against a stored reference record. The correlation runs in the time domain over every lag from 0 to N-1, with N = 2048 samples of 12 bits by default. A measured record is written into one half of a two-bank capture store. While one bank is being filled, a single multiply-accumulate engine sweeps the lags of the other bank.

For each lag j, the engine sums ref(n)·meas(n+j) over the indices where n+j stays inside the record, so there is no wrap-around. It divides the sum by N with round-half-up and emits one signed result per lag, in increasing lag order. Each result is tagged with its lag, and the final one is marked as last. A downstream ready signal freezes the engine.

The reference is built on chip. With the reference-load input high at the first sample of a record, that record is averaged into the reference instead of being correlated. After K = 2^k such records, the rounded mean becomes the new reference.

Top module: `xcorr_engine`

## Requirements
- R1: While rst_n is low, and after its release before any input, res_valid, busy and overrun are 0.
- R2: A record whose first sample arrives with ref_mode high produces no result and leaves busy at 0. After K = 2^ref_avg_log2 such records (ref_avg_log2 from 0 to 4, sampled at each record's first sample), the reference at index i becomes floor((sum of the K samples at i + K/2) / K). For K = 1 there is no offset.
- R3: For a measured record m and the current reference r, the result at lag j equals floor((S + N/2) / N), where S is the sum of r(n)·m(n+j) over n = 0 .. N-1-j. All samples are two's complement, and res_data is a signed 2·SAMP_W-bit value.
- R4: The results of one record appear with res_lag = 0, 1, .., N-1 in that order. res_last is 1 exactly on lag N-1.
- R5: While res_valid is 1 and res_ready is 0, res_valid, res_data, res_lag and res_last hold their values.
- R6: Full-scale inputs do not overflow. With every reference and measured sample at the most negative code, lag 0 yields 2^(2·SAMP_W-2).
- R7: busy rises in the cycle after the last sample of a measured record. It stays high while any measured record is stored, being swept, or has results not yet accepted. It falls after the last result of the last pending record is accepted.
- R8: A second measured record can be captured while the first is being processed. Both records' results are delivered in capture order.
- R9: A measured record that starts while both banks hold unfinished records is dropped completely and produces no results. overrun goes to 1 and stays at 1 until reset.
- R10: A sample is taken only in a cycle with in_valid high. Idle cycles may separate samples of a record, and N accepted samples form one record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMP_W | Signed input sample |
| ref_mode | input | 1 | Record is a reference contribution (sampled at the record's first sample) |
| ref_avg_log2 | input | 3 | log2 of the number of records averaged into the reference |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Downstream accepts the result |
| res_data | output | 2*SAMP_W | Normalised correlation value, signed |
| res_lag | output | log2(N_SAMP) | Lag of the current result |
| res_last | output | 1 | Result is for lag N-1 |
| busy | output | 1 | A measured record is pending or in flight |
| overrun | output | 1 | Sticky: a measured record was dropped |

## Verification
The bound checker checks every cycle that a held result stays frozen under backpressure, that lags step by one from zero and the last flag marks lag N-1, that busy covers every valid result, and that overrun never clears. The numerical content has to be shown by the bench's scenarios, because only whole records give a known answer to compare against. That content covers the rounded correlation sums, the truncated lag windows, the averaged and rounded reference, full-scale arithmetic, and the ordering and dropping of back-to-back records. The bench runs these on an eight-sample configuration and computes every lag of every record arithmetically.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

  // How the record currently being received is handled
  typedef enum logic [1:0] {
    REC_MEAS = 2'd0,  // store into a capture bank for correlation
    REC_REF  = 2'd1,  // add into the reference average
    REC_DROP = 2'd2   // no bank free: discard
  } rec_mode_e;

endpackage

// File: rtl/xcorr_rnd_shift.sv
// Signed arithmetic right shift with round-half-up: (din + 2^(sh-1)) >>> sh
module xcorr_rnd_shift #(
  parameter int IN_W  = 35,
  parameter int OUT_W = 24,
  parameter int SH_W  = 4
) (
  input  logic [IN_W-1:0]  din,
  input  logic [SH_W-1:0]  sh,
  output logic [OUT_W-1:0] dout
);

  logic signed [IN_W:0] ext;
  logic signed [IN_W:0] half;
  logic signed [IN_W:0] biased;
  logic signed [IN_W:0] shifted;

  always_comb begin
    ext     = signed'({din[IN_W-1], din});
    half    = (sh == '0) ? '0 : ((IN_W+1)'(1) << (sh - 1'b1));
    biased  = ext + half;
    shifted = biased >>> sh;
    dout    = OUT_W'(shifted);
  end

endmodule

// File: rtl/xcorr_capture.sv
// Input side: two measurement banks, reference averaging, bank ownership
module xcorr_capture
  import xcorr_pkg::*;
#(
  parameter int N_SAMP    = 2048,
  parameter int SAMP_W    = 12,
  parameter int KMAX_LOG2 = 4,
  localparam int LAG_W    = $clog2(N_SAMP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] in_sample,
  input  logic              ref_mode,
  input  logic [2:0]        ref_avg_log2,
  input  logic              rd_sel,
  input  logic              rel_en,
  input  logic [LAG_W-1:0]  meas_addr,
  input  logic [LAG_W-1:0]  ref_addr,
  output logic [SAMP_W-1:0] meas_q,
  output logic [SAMP_W-1:0] ref_q,
  output logic [1:0]        full,
  output logic              overrun
);

  localparam int CNT_W = (KMAX_LOG2 < 1) ? 1 : KMAX_LOG2;
  localparam int AVG_W = SAMP_W + CNT_W;
  localparam logic [LAG_W-1:0] LAST_IDX = LAG_W'(N_SAMP - 1);

  logic [LAG_W-1:0] wr_idx_q, wr_idx_d;
  logic             wr_sel_q, wr_sel_d;
  rec_mode_e        mode_q, mode_d, mode_cur;
  logic [2:0]       klog_q, klog_d, klog_cur, klog_in;
  logic [CNT_W-1:0] rcnt_q, rcnt_d;
  logic [1:0]       full_q, full_d;
  logic             ovr_q, ovr_d;

  logic             rec_start, rec_end;
  logic             bank_we, avg_we, ref_we;
  logic             ref_first, ref_final;
  logic [CNT_W:0]   kmax_cnt;
  logic [AVG_W-1:0] avg_rd, avg_sum;
  logic [SAMP_W-1:0] ref_rnd;

  logic [SAMP_W-1:0] bank_rd [2];
  logic [AVG_W-1:0]  avg_mem [N_SAMP];
  logic [SAMP_W-1:0] ref_mem [N_SAMP];

  // ---------------- record control, next state ----------------
  always_comb begin
    rec_start = in_valid && (wr_idx_q == '0);
    rec_end   = in_valid && (wr_idx_q == LAST_IDX);
    klog_in   = (ref_avg_log2 > 3'(KMAX_LOG2)) ? 3'(KMAX_LOG2) : ref_avg_log2;

    if (rec_start) begin
      klog_cur = klog_in;
      if (ref_mode)                 mode_cur = REC_REF;
      else if (full_q[wr_sel_q])    mode_cur = REC_DROP;
      else                          mode_cur = REC_MEAS;
    end else begin
      klog_cur = klog_q;
      mode_cur = mode_q;
    end

    kmax_cnt  = (CNT_W+1)'((1 << klog_cur) - 1);
    ref_first = (rcnt_q == '0);
    ref_final = ({1'b0, rcnt_q} == kmax_cnt);

    bank_we = in_valid && (mode_cur == REC_MEAS);
    avg_we  = in_valid && (mode_cur == REC_REF);
    ref_we  = avg_we && ref_final;

    avg_rd  = avg_mem[wr_idx_q];
    avg_sum = (ref_first ? '0 : avg_rd) + {{CNT_W{in_sample[SAMP_W-1]}}, in_sample};

    wr_idx_d = wr_idx_q;
    wr_sel_d = wr_sel_q;
    mode_d   = mode_q;
    klog_d   = klog_q;
    rcnt_d   = rcnt_q;
    full_d   = full_q;
    ovr_d    = ovr_q;

    if (in_valid) begin
      wr_idx_d = rec_end ? '0 : wr_idx_q + 1'b1;
      mode_d   = mode_cur;
      klog_d   = klog_cur;
    end
    if (rel_en) full_d[rd_sel] = 1'b0;
    if (rec_end && (mode_cur == REC_MEAS)) begin
      full_d[wr_sel_q] = 1'b1;
      wr_sel_d         = ~wr_sel_q;
    end
    if (rec_end && (mode_cur == REC_REF)) begin
      rcnt_d = ref_final ? '0 : rcnt_q + 1'b1;
    end
    if (rec_start && (mode_cur == REC_DROP)) ovr_d = 1'b1;
  end

  // ---------------- state registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      wr_sel_q <= 1'b0;
      mode_q   <= REC_MEAS;
      klog_q   <= '0;
      rcnt_q   <= '0;
      full_q   <= '0;
      ovr_q    <= 1'b0;
    end else begin
      wr_idx_q <= wr_idx_d;
      wr_sel_q <= wr_sel_d;
      mode_q   <= mode_d;
      klog_q   <= klog_d;
      rcnt_q   <= rcnt_d;
      full_q   <= full_d;
      ovr_q    <= ovr_d;
    end
  end

  // ---------------- measurement banks ----------------
  for (genvar gb = 0; gb < 2; gb++) begin : g_bank
    logic [SAMP_W-1:0] mem [N_SAMP];
    always_ff @(posedge clk) begin
      if (bank_we && (wr_sel_q == 1'(gb))) mem[wr_idx_q] <= in_sample;
    end
    assign bank_rd[gb] = mem[meas_addr];
  end

  // ---------------- reference averaging ----------------
  xcorr_rnd_shift #(
    .IN_W (AVG_W),
    .OUT_W(SAMP_W),
    .SH_W (3)
  ) u_avg_rnd (
    .din (avg_sum),
    .sh  (klog_cur),
    .dout(ref_rnd)
  );

  always_ff @(posedge clk) begin
    if (avg_we) avg_mem[wr_idx_q] <= avg_sum;
    if (ref_we) ref_mem[wr_idx_q] <= ref_rnd;
  end

  assign meas_q  = bank_rd[rd_sel];
  assign ref_q   = ref_mem[ref_addr];
  assign full    = full_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/xcorr_mac.sv
// Lag sweep: one product per cycle, truncated window, rounded 1/N scaling
module xcorr_mac #(
  parameter int N_SAMP = 2048,
  parameter int SAMP_W = 12,
  localparam int LAG_W = $clog2(N_SAMP),
  localparam int RES_W = 2 * SAMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        full,
  input  logic [SAMP_W-1:0] meas_q,
  input  logic [SAMP_W-1:0] ref_q,
  input  logic              res_ready,
  output logic [LAG_W-1:0]  meas_addr,
  output logic [LAG_W-1:0]  ref_addr,
  output logic              rd_sel,
  output logic              rel_en,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic [LAG_W-1:0]  res_lag,
  output logic              res_last
);

  localparam int PROD_W = 2 * SAMP_W;
  localparam int ACC_W  = PROD_W + LAG_W;
  localparam int SH_W   = $clog2(LAG_W + 1);
  localparam logic [LAG_W-1:0] LAST_IDX = LAG_W'(N_SAMP - 1);

  logic                    run_q, run_d;
  logic [LAG_W-1:0]        j_q, j_d, n_q, n_d;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic                    sel_q, sel_d;
  logic                    vld_q, vld_d;
  logic [RES_W-1:0]        dat_q, dat_d;
  logic [LAG_W-1:0]        lag_q, lag_d;
  logic                    lst_q, lst_d;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  mac_sum;
  logic [RES_W-1:0]         scaled;
  logic                     stall, step, fin;

  xcorr_rnd_shift #(
    .IN_W (ACC_W),
    .OUT_W(RES_W),
    .SH_W (SH_W)
  ) u_out_rnd (
    .din (mac_sum),
    .sh  (SH_W'(LAG_W)),
    .dout(scaled)
  );

  always_comb begin
    prod    = $signed(ref_q) * $signed(meas_q);
    mac_sum = acc_q + {{LAG_W{prod[PROD_W-1]}}, prod};
    stall   = vld_q && !res_ready;
    step    = run_q && !stall;
    fin     = (n_q == (LAST_IDX - j_q));

    run_d  = run_q;
    j_d    = j_q;
    n_d    = n_q;
    acc_d  = acc_q;
    sel_d  = sel_q;
    vld_d  = vld_q;
    dat_d  = dat_q;
    lag_d  = lag_q;
    lst_d  = lst_q;
    rel_en = 1'b0;

    if (vld_q && res_ready) vld_d = 1'b0;

    if (!run_q) begin
      if (full[sel_q]) begin
        run_d = 1'b1;
        j_d   = '0;
        n_d   = '0;
        acc_d = '0;
      end
    end else if (step) begin
      if (fin) begin
        vld_d = 1'b1;
        dat_d = scaled;
        lag_d = j_q;
        lst_d = (j_q == LAST_IDX);
        acc_d = '0;
        n_d   = '0;
        if (j_q == LAST_IDX) begin
          run_d  = 1'b0;
          rel_en = 1'b1;
          sel_d  = ~sel_q;
        end else begin
          j_d = j_q + 1'b1;
        end
      end else begin
        n_d   = n_q + 1'b1;
        acc_d = mac_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      j_q   <= '0;
      n_q   <= '0;
      acc_q <= '0;
      sel_q <= 1'b0;
      vld_q <= 1'b0;
      dat_q <= '0;
      lag_q <= '0;
      lst_q <= 1'b0;
    end else begin
      run_q <= run_d;
      j_q   <= j_d;
      n_q   <= n_d;
      acc_q <= acc_d;
      sel_q <= sel_d;
      vld_q <= vld_d;
      dat_q <= dat_d;
      lag_q <= lag_d;
      lst_q <= lst_d;
    end
  end

  assign ref_addr  = n_q;
  assign meas_addr = n_q + j_q;
  assign rd_sel    = sel_q;
  assign res_valid = vld_q;
  assign res_data  = dat_q;
  assign res_lag   = lag_q;
  assign res_last  = lst_q;

endmodule

// File: rtl/xcorr_engine.sv
module xcorr_engine #(
  parameter int N_SAMP    = 2048,
  parameter int SAMP_W    = 12,
  parameter int KMAX_LOG2 = 4,
  localparam int LAG_W    = $clog2(N_SAMP),
  localparam int RES_W    = 2 * SAMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] in_sample,
  input  logic              ref_mode,
  input  logic [2:0]        ref_avg_log2,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  res_data,
  output logic [LAG_W-1:0]  res_lag,
  output logic              res_last,
  output logic              busy,
  output logic              overrun
);

  logic [1:0]        full;
  logic              rd_sel, rel_en;
  logic [LAG_W-1:0]  meas_addr, ref_addr;
  logic [SAMP_W-1:0] meas_q, ref_q;

  xcorr_capture #(
    .N_SAMP   (N_SAMP),
    .SAMP_W   (SAMP_W),
    .KMAX_LOG2(KMAX_LOG2)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sample   (in_sample),
    .ref_mode    (ref_mode),
    .ref_avg_log2(ref_avg_log2),
    .rd_sel      (rd_sel),
    .rel_en      (rel_en),
    .meas_addr   (meas_addr),
    .ref_addr    (ref_addr),
    .meas_q      (meas_q),
    .ref_q       (ref_q),
    .full        (full),
    .overrun     (overrun)
  );

  xcorr_mac #(
    .N_SAMP(N_SAMP),
    .SAMP_W(SAMP_W)
  ) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .full     (full),
    .meas_q   (meas_q),
    .ref_q    (ref_q),
    .res_ready(res_ready),
    .meas_addr(meas_addr),
    .ref_addr (ref_addr),
    .rd_sel   (rd_sel),
    .rel_en   (rel_en),
    .res_valid(res_valid),
    .res_data (res_data),
    .res_lag  (res_lag),
    .res_last (res_last)
  );

  assign busy = (|full) | res_valid;

endmodule

// File: rtl/xcorr_checker.sv
module xcorr_checker #(
  parameter int N_SAMP = 2048,
  parameter int RES_W  = 24,
  localparam int LAG_W = $clog2(N_SAMP)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_data,
  input logic [LAG_W-1:0] res_lag,
  input logic             res_last,
  input logic             busy,
  input logic             overrun
);

  // lag the next presented result must carry
  logic [LAG_W-1:0] exp_lag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_lag <= '0;
    else if (res_valid && res_ready) exp_lag <= res_last ? '0 : res_lag + 1'b1;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_lag) && $stable(res_last));

  assert_last_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_last == (res_lag == LAG_W'(N_SAMP - 1))));

  assert_lag_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_lag == exp_lag));

  assert_busy_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

bind xcorr_engine xcorr_checker #(
  .N_SAMP(N_SAMP),
  .RES_W (RES_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_data (res_data),
  .res_lag  (res_lag),
  .res_last (res_last),
  .busy     (busy),
  .overrun  (overrun)
);

// File: tb/tb_xcorr_engine.sv
`timescale 1ns/1ps
module tb_xcorr_engine;

  localparam int NS = 8;
  localparam int LW = 3;
  localparam int SW = 12;
  localparam int RW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [SW-1:0] in_sample;
  logic          ref_mode;
  logic [2:0]    ref_avg_log2;
  logic          res_valid, res_ready, res_last, busy, overrun;
  logic [RW-1:0] res_data;
  logic [LW-1:0] res_lag;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int ref_mdl [NS];

  always #4 clk = ~clk;

  xcorr_engine #(.N_SAMP(NS), .SAMP_W(SW), .KMAX_LOG2(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .ref_mode(ref_mode), .ref_avg_log2(ref_avg_log2),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_lag(res_lag), .res_last(res_last), .busy(busy), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_r(input int j, input int m[NS]);
    longint s = 0;
    for (int n = 0; n + j < NS; n++) s += longint'(ref_mdl[n]) * longint'(m[n + j]);
    return (s + NS / 2) >>> LW;
  endfunction

  // R10: drives one record, optionally with idle cycles between samples
  task automatic send(input int r[NS], input bit is_ref, input bit gaps);
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = SW'(r[i]);
      ref_mode  = is_ref;
      if (gaps && (i % 2 == 1)) begin
        @(negedge clk);
        in_valid  = 1'b0;
        ref_mode  = ~is_ref;  // ignored mid-record
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    ref_mode = 1'b0;
  endtask

  // loads the reference from k records and updates the bench model (R2)
  task automatic load_ref(input int caps[16][NS], input int klog);
    int kk = 1 << klog;
    ref_avg_log2 = 3'(klog);
    for (int c = 0; c < kk; c++) begin
      send(caps[c], 1'b1, c == 0);
      check(busy == 1'b0, "R2", "busy after reference record", busy, 0);
    end
    repeat (NS * NS) @(negedge clk);
    check(res_valid == 1'b0, "R2", "no result from reference records", res_valid, 0);
    for (int i = 0; i < NS; i++) begin
      int s = 0;
      for (int c = 0; c < kk; c++) s += caps[c][i];
      ref_mdl[i] = (s + kk / 2) >>> klog;
    end
  endtask

  // collects one record's results; rmode 1 throttles ready
  task automatic collect(input int m[NS], input int rmode, input string req);
    bit     held_v = 1'b0;
    logic [RW-1:0] held_d = '0;
    for (int j = 0; j < NS; j++) begin
      bit got = 1'b0;
      while (!got) begin
        bit r;
        @(negedge clk);
        cyc++;
        if (held_v) begin
          check(res_valid && (res_data == held_d), "R5", "stalled result held",
                longint'($signed(res_data)), longint'($signed(held_d)));
        end
        r = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
        res_ready = r;
        held_v = res_valid && !r;
        held_d = res_data;
        if (res_valid && r) begin
          got = 1'b1;
          check(longint'($signed(res_data)) == exp_r(j, m), req, $sformatf("value lag %0d", j),
                longint'($signed(res_data)), exp_r(j, m));
          check(int'(res_lag) == j, "R4", "lag index", res_lag, j);
          check(res_last == (j == NS - 1), "R4", "last flag", res_last, j == NS - 1);
        end
      end
    end
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int caps [16][NS];
    int m1 [NS];
    int m2 [NS];
    int m3 [NS];

    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; ref_mode = 1'b0;
    ref_avg_log2 = '0; res_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!res_valid && !busy && !overrun, "R1", "outputs in reset",
          {res_valid, busy, overrun}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!res_valid && !busy && !overrun, "R1", "outputs after reset",
          {res_valid, busy, overrun}, 0);

    // K=1 reference, general pattern, gapped input, full-rate ready (R3, R10)
    caps[0] = '{100, -200, 300, -400, 5, -6, 2047, -2048};
    load_ref(caps, 0);
    m1 = '{-7, 1500, -333, 12, 2047, -2048, 64, 900};
    send(m1, 1'b0, 1'b1);
    check(busy == 1'b1, "R7", "busy after capture end", busy, 1);
    collect(m1, 0, "R3");
    check(busy == 1'b0, "R7", "busy after last accept", busy, 0);

    // output rounding half-up on both signs (R3)
    caps[0] = '{1, 0, 0, 0, 0, 0, 0, 0};
    load_ref(caps, 0);
    m1 = '{4, -4, 12, -12, 20, -20, 3, -3};
    send(m1, 1'b0, 1'b0);
    collect(m1, 0, "R3");

    // K=2 averaging with half-up rounding of negative and positive halves (R2)
    caps[0] = '{-3, 3, 1, -1, 0, 0, 0, 0};
    caps[1] = '{0, 0, 0, 0, 0, 0, 0, 0};
    load_ref(caps, 1);
    check(ref_mdl[0] == -1 && ref_mdl[1] == 2, "R2", "bench reference model", ref_mdl[0], -1);
    m1 = '{1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000};
    send(m1, 1'b0, 1'b0);
    collect(m1, 0, "R2");

    // K=4 averaging of varied records, throttled ready (R2, R5)
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < NS; i++) caps[c][i] = ((c * 1237 + i * 613 + 91) % 4096) - 2048;
    load_ref(caps, 2);
    m1 = '{2047, -1, -2048, 777, -1234, 55, 0, 1999};
    send(m1, 1'b0, 1'b0);
    collect(m1, 1, "R2");

    // full-scale: most negative code everywhere (R6)
    for (int i = 0; i < NS; i++) caps[0][i] = -2048;
    load_ref(caps, 0);
    for (int i = 0; i < NS; i++) m1[i] = -2048;
    send(m1, 1'b0, 1'b0);
    check(exp_r(0, m1) == (64'sd1 << 22), "R6", "bench full-scale lag 0", exp_r(0, m1), 1 << 22);
    collect(m1, 1, "R6");

    // ping-pong, then a dropped third record (R8, R9)
    caps[0] = '{300, -20, 11, 0, -900, 47, 1, -5};
    load_ref(caps, 0);
    m1 = '{1, 2, 3, 4, 5, 6, 7, 8};
    m2 = '{-800, 400, -200, 100, -50, 25, -12, 6};
    m3 = '{2000, 2000, 2000, 2000, 2000, 2000, 2000, 2000};
    send(m1, 1'b0, 1'b0);
    send(m2, 1'b0, 1'b0);
    check(overrun == 1'b0, "R8", "second record accepted", overrun, 0);
    send(m3, 1'b0, 1'b0);
    check(overrun == 1'b1, "R9", "third record overrun", overrun, 1);
    collect(m1, 1, "R8");
    check(busy == 1'b1, "R7", "busy with second record pending", busy, 1);
    collect(m2, 0, "R8");
    repeat (NS * NS * 2) @(negedge clk);
    check(res_valid == 1'b0, "R9", "dropped record gives no result", res_valid, 0);
    check(busy == 1'b0, "R9", "idle after dropped record", busy, 0);
    check(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule